// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder (16-bit)

This block adds two 16-bit operands and a carry-in. The operands are split into four 4-bit slices. Each slice forms per-bit generate (a AND b) and propagate (a OR b) terms. From these it computes its internal carries in flat sum-of-products form and derives one block-level generate/propagate pair. A second lookahead unit applies the same equations across the four slices to produce every slice carry-in at once, so no carry ripples from one slice to the next.

The sum, the carry-out and the 16-bit block propagate/generate pair are captured in one output register stage with a synchronous active-high reset. The block propagate/generate pair lets four instances feed a further lookahead level to form a 64-bit adder. Subtraction control and overflow detection belong to the surrounding datapath and are not part of this block.

Top module: `cla16_adder`

## Requirements
- R1: On each rising clock edge with reset low, `sum` takes the low 16 bits of `op_a + op_b + c_in` sampled at that edge, so the result is seen one cycle after the operands.
- R2: Reset is synchronous and active high: an edge with `rst` high clears `sum`, `c_out`, `blk_p` and `blk_g` to 0, and raising `rst` between edges leaves the outputs unchanged until the next edge.
- R3: `c_out` is bit 16 of the 17-bit result `op_a + op_b + c_in` registered with the sum.
- R4: `blk_p` is 1 exactly when every one of the 16 bit positions has `op_a` or `op_b` set (the AND of all bit propagate terms `a|b`).
- R5: `blk_g` is 1 exactly when `op_a + op_b` with carry-in 0 produces a carry out of bit 15, whatever the value of `c_in`.
- R6: `c_out` equals `blk_g OR (blk_p AND c_in)` for the same registered operation.
- R7: A carry-in of 1 travels through all four slices: `op_a = 16'hFFFF`, `op_b = 0`, `c_in = 1` gives `sum = 0` and `c_out = 1`.
- R8: A carry formed in the top bit of slice k (bits 3, 7, 11) enters slice k+1 correctly, for example `16'h000F + 1 = 16'h0010` and `16'h0FFF + 1 = 16'h1000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Registered sum |
| c_out | output | 1 | Registered carry out of bit 15 |
| blk_p | output | 1 | Registered block propagate of the 16-bit adder |
| blk_g | output | 1 | Registered block generate of the 16-bit adder |

## Verification
The bench targets carries that must cross slice boundaries: operands whose lower slices are all ones, plus a carry-in that must cross all 16 bits. A design that dropped or mis-ordered a term in the second-level lookahead would return a sum missing a one at bit 4, 8 or 12. It would also leave the upper slices unchanged when a full-width carry is expected. The all-ones and all-zeros operands separate a generate from a propagate: the case `16'h0F0F + 16'hF0F0` has propagate set and generate clear, so `c_out` depends on `c_in` alone. A swapped or mis-built block term would show a wrong `blk_p`/`blk_g` pair or a carry-out that ignores `c_in`. A reset raised between edges checks that the clear waits for the clock edge.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int GW   = 4;        // bits per lookahead slice
    localparam int NG   = 4;        // slices per adder
    localparam int LA_N = 4;        // fan-in of one lookahead unit
    localparam int W    = GW * NG;  // adder width

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    typedef logic [LA_N-1:0] lvec_t;

    // Carries c[0..LA_N] in flat sum-of-products form.
    // c[i] = c0*p[0..i-1] OR sum over j<i of g[j]*p[j+1..i-1]
    function automatic logic [LA_N:0] la_carries(lvec_t g, lvec_t p, logic c0);
        logic [LA_N:0] c;
        logic          t;
        c    = '0;
        c[0] = c0;
        for (int i = 1; i <= LA_N; i++) begin
            t = c0;
            for (int k = 0; k < i; k++) t = t & p[k];
            c[i] = t;
            for (int j = 0; j < i; j++) begin
                t = g[j];
                for (int k = j + 1; k < i; k++) t = t & p[k];
                c[i] = c[i] | t;
            end
        end
        return c;
    endfunction

    // Block-level propagate/generate of LA_N positions.
    function automatic pg_t la_block(lvec_t g, lvec_t p);
        pg_t           r;
        logic [LA_N:0] c;
        c   = la_carries(g, p, 1'b0);
        r.p = &p;
        r.g = c[LA_N];
        return r;
    endfunction

endpackage

// File: rtl/cla_bitcell.sv
module cla_bitcell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic g,
    output logic p,
    output logic s
);
    assign g = a & b;
    assign p = a | b;
    assign s = a ^ b ^ c;
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
(
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] s,
    output pg_t           blk
);
    logic [GW-1:0] g_bit;
    logic [GW-1:0] p_bit;
    logic [GW:0]   c_bit;

    assign c_bit = la_carries(g_bit, p_bit, cin);
    assign blk   = la_block(g_bit, p_bit);

    for (genvar i = 0; i < GW; i++) begin : g_bits
        cla_bitcell u_cell (
            .a (a[i]),
            .b (b[i]),
            .c (c_bit[i]),
            .g (g_bit[i]),
            .p (p_bit[i]),
            .s (s[i])
        );
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
(
    input  pg_t           grp [NG],
    input  logic          cin,
    output logic [NG-1:0] carry,
    output pg_t           top
);
    lvec_t         gv;
    lvec_t         pv;
    logic [NG:0]   c_all;

    always_comb begin
        for (int i = 0; i < NG; i++) begin
            gv[i] = grp[i].g;
            pv[i] = grp[i].p;
        end
    end

    assign c_all = la_carries(gv, pv, cin);
    assign carry = c_all[NG-1:0];
    assign top   = la_block(gv, pv);
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [15:0]  op_a,
    input  logic [15:0]  op_b,
    input  logic         c_in,
    output logic [15:0]  sum,
    output logic         c_out,
    output logic         blk_p,
    output logic         blk_g
);
    pg_t           grp_pg [NG];
    logic [NG-1:0] grp_cin;
    pg_t           all_pg;
    logic [W-1:0]  sum_d;
    logic          cout_d;

    for (genvar k = 0; k < NG; k++) begin : g_slice
        cla_group u_grp (
            .a   (op_a[k*GW +: GW]),
            .b   (op_b[k*GW +: GW]),
            .cin (grp_cin[k]),
            .s   (sum_d[k*GW +: GW]),
            .blk (grp_pg[k])
        );
    end

    cla_lookahead u_la (
        .grp   (grp_pg),
        .cin   (c_in),
        .carry (grp_cin),
        .top   (all_pg)
    );

    assign cout_d = all_pg.g | (all_pg.p & c_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum   <= '0;
            c_out <= 1'b0;
            blk_p <= 1'b0;
            blk_g <= 1'b0;
        end else begin
            sum   <= sum_d;
            c_out <= cout_d;
            blk_p <= all_pg.p;
            blk_g <= all_pg.g;
        end
    end
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        c_in,
    input logic [15:0] sum,
    input logic        c_out,
    input logic        blk_p,
    input logic        blk_g
);
    // R1 and R3: registered 17-bit result
    p_sum_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> {c_out, sum} ==
            (17'($past(op_a)) + 17'($past(op_b)) + 17'($past(c_in))));

    p_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sum == 16'h0 && !c_out && !blk_p && !blk_g));

    p_prop_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> blk_p == (&($past(op_a) | $past(op_b))));

    p_gen_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> blk_g ==
            ((17'($past(op_a)) + 17'($past(op_b))) >= 17'h10000));

    p_cout_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> c_out == (blk_g | (blk_p & $past(c_in))));
endmodule

bind cla16_adder cla16_adder_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .op_a  (op_a),
    .op_b  (op_b),
    .c_in  (c_in),
    .sum   (sum),
    .c_out (c_out),
    .blk_p (blk_p),
    .blk_g (blk_g)
);

// File: tb/sim_cla16_adder.sv
module sim_cla16_adder;

    typedef struct {
        logic [15:0] s;
        logic        co;
        logic        p;
        logic        g;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = 16'hABCD;
    logic [15:0] op_b = 16'h1234;
    logic        c_in = 1'b1;
    logic [15:0] sum;
    logic        c_out;
    logic        blk_p;
    logic        blk_g;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    cla16_adder u0 (
        .clk   (clk),
        .rst   (rst),
        .op_a  (op_a),
        .op_b  (op_b),
        .c_in  (c_in),
        .sum   (sum),
        .c_out (c_out),
        .blk_p (blk_p),
        .blk_g (blk_g)
    );

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input string tag);
        exp_t        e;
        logic [16:0] full;
        @(negedge clk);
        op_a = a;
        op_b = b;
        c_in = ci;
        full  = 17'(a) + 17'(b) + 17'(ci);
        e.s   = full[15:0];
        e.co  = full[16];
        e.p   = &(a | b);
        e.g   = (17'(a) + 17'(b)) >= 17'h10000;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares one registered result per clock edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (!rst && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (sum !== e.s || c_out !== e.co || blk_p !== e.p || blk_g !== e.g) begin
                errors++;
                $display("FAIL %s: got sum=%h co=%b p=%b g=%b expected sum=%h co=%b p=%b g=%b",
                         e.tag, sum, c_out, blk_p, blk_g, e.s, e.co, e.p, e.g);
            end
        end
    end

    task automatic check_zero(input string tag);
        checks++;
        if (sum !== 16'h0 || c_out !== 1'b0 || blk_p !== 1'b0 || blk_g !== 1'b0) begin
            errors++;
            $display("FAIL %s: got sum=%h co=%b p=%b g=%b expected all zero",
                     tag, sum, c_out, blk_p, blk_g);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero("R2 reset state");
        rst = 1'b0;
        sb_q.delete();

        drive(16'h0000, 16'h0000, 1'b0, "R1 zeros");
        drive(16'h0000, 16'h0000, 1'b1, "R1 zeros carry-in");
        drive(16'hFFFF, 16'h0000, 1'b1, "R7 carry through all slices");
        drive(16'h0000, 16'hFFFF, 1'b1, "R7 carry through all slices swapped");
        drive(16'hFFFF, 16'hFFFF, 1'b0, "R3 all ones no carry-in");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R3 all ones with carry-in");
        drive(16'h000F, 16'h0001, 1'b0, "R8 slice0 to slice1");
        drive(16'h00FF, 16'h0001, 1'b0, "R8 slice1 to slice2");
        drive(16'h0FFF, 16'h0001, 1'b0, "R8 slice2 to slice3");
        drive(16'h00F0, 16'h0010, 1'b0, "R8 generate in slice1");
        drive(16'h0F0F, 16'hF0F0, 1'b0, "R6 propagate only, cin 0");
        drive(16'h0F0F, 16'hF0F0, 1'b1, "R6 propagate only, cin 1");
        drive(16'h8000, 16'h8000, 1'b0, "R5 generate at msb");
        drive(16'h8000, 16'h8000, 1'b1, "R5 generate with cin");
        drive(16'h7FFF, 16'h0000, 1'b1, "R4 propagate clear");
        for (int i = 0; i < 200; i++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
        end

        // R2: reset raised between edges waits for the edge
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R1 before reset");
        @(posedge clk);
        #4;
        @(negedge clk);
        rst = 1'b1;
        #1;
        checks++;
        if (sum !== 16'hFFFF || c_out !== 1'b1) begin
            errors++;
            $display("FAIL R2 synchronous: got sum=%h co=%b expected sum=ffff co=1",
                     sum, c_out);
        end
        @(posedge clk);
        #2;
        check_zero("R2 reset after edge");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

endmodule